// File: doc/BRIEF.md
# Fair Crossbar Epoch Allocator

This block chooses which source card may send to which destination card in the next epoch on a 15-port switched backplane. A pulse on `start` captures three inputs. The first is a request matrix with one bit for each source/destination pair. The second is a vector of destinations that are asking to be left alone. The third is a flag for each source that marks it as a forwarding-engine card. The block then builds a set of pairings in which no source and no destination appears twice. It signals the result with a one-cycle `done` pulse. The grants stay on the outputs until the next result replaces them.

A fixed scan order would always favour the same sources. To avoid this, each epoch the allocator rotates the source order and the destination order by offsets taken from a free-running pseudo-random register that steps once per accepted epoch. The permuted matrix is walked by wrapped diagonals. All cells on one diagonal share no row and no column, so they are decided together. Several diagonals are chained in each clock cycle so that the whole matrix is covered inside the epoch budget. The walk runs twice. The first pass matches only forwarding-engine sources. The second pass matches line-card sources on whatever ports are still free.

Top module: `xbar_alloc`

## Requirements
- R1: While reset is held and after it is released, `done` is low and every bit of `grant_vld` is low until the first result.
- R2: `done` is a single-cycle pulse. It rises exactly 2*ceil(N/D) clock cycles after the edge that accepts `start` (8 cycles with the defaults).
- R3: In a result, no destination index is granted to more than one source, and every granted index is below N.
- R4: Source s is granted destination d (`grant_vld[s]`=1 and `grant_dst[s*IW +: IW]`=d) only if request bit `req[s*N+d]` was set.
- R5: A destination whose `inhibit` bit was set is never granted.
- R6: A result is maximal. No ungranted source holds a request to a destination that is neither inhibited nor granted.
- R7: Forwarding-engine sources go first. If a source with its `fe_card` bit set is left ungranted while it requests a non-inhibited destination d, then d was granted to another forwarding-engine source.
- R8: `req`, `inhibit` and `fe_card` are sampled only on the edge that accepts `start`. Changing them during allocation has no effect on the result.
- R9: A `start` pulse that arrives while allocation is in progress is ignored and produces no extra result.
- R10: Over many epochs, two line-card sources that contend for one destination each win it a substantial share of the time, not always the lower-numbered one.
- R11: `grant_vld` and `grant_dst` change only together with a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Allocation clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Epoch start; accepted only when idle |
| req | input | N*N | Request matrix; bit s*N+d means source s wants destination d |
| inhibit | input | N | Destination d refuses traffic this epoch |
| fe_card | input | N | Source s is a forwarding-engine card |
| done | output | 1 | One-cycle pulse marking a fresh grant set |
| grant_vld | output | N | Source s holds a grant |
| grant_dst | output | N*IW | Destination index for source s at bits s*IW +: IW |

## Verification
The hardest cases to reach are those where the order of the shuffle decides the result. These are a contested destination between two line cards, and a forwarding-engine source competing with a line card. One epoch shows only one random offset. The bench therefore repeats the same contested pattern over dozens of epochs and counts wins on each side. It also confirms that the forwarding-engine card wins under every offset. Late input sampling is provoked by an all-ones request matrix whose inputs are replaced by all-inhibit and an empty request matrix, together with a second `start`, while the first allocation is still running. Randomly filled matrices of varying density then exercise maximality and priority. Those checks are made against the request set that was captured.

// File: rtl/xbar_alloc_pkg.sv
package xbar_alloc_pkg;

  // Add two indices below n and wrap the result back into 0..n-1.
  function automatic int wrap_add(int a, int b, int n);
    int t;
    t = a + b;
    if (t >= n) t = t - n;
    return t;
  endfunction

  // Counter width that is never zero.
  function automatic int width_min1(int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/xbar_lfsr.sv
module xbar_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] state
);

  // Galois form: shift right, fold the tap mask back in on a one out.
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEED;
    end else if (adv) begin
      state <= (state >> 1) ^ (state[0] ? TAPS : '0);
    end
  end

endmodule

// File: rtl/xbar_diag_stage.sv
module xbar_diag_stage
  import xbar_alloc_pkg::*;
#(
  parameter int N  = 15,
  parameter int D  = 4,
  parameter int J  = 0,
  parameter int CW = 2,
  parameter int IW = 4
) (
  input  logic [CW-1:0]   cyc,
  input  logic            pass_lc,
  input  logic [N*N-1:0]  req,
  input  logic [N-1:0]    inh,
  input  logic [N-1:0]    fe,
  input  logic [IW-1:0]   rs,
  input  logic [IW-1:0]   rd,
  input  logic [N-1:0]    sb_i,
  input  logic [N-1:0]    db_i,
  input  logic [N-1:0]    gv_i,
  input  logic [N*IW-1:0] gd_i,
  output logic [N-1:0]    sb_o,
  output logic [N-1:0]    db_o,
  output logic [N-1:0]    gv_o,
  output logic [N*IW-1:0] gd_o
);

  // One wrapped diagonal of the rotated matrix. Its cells touch distinct
  // rows and columns, so every cell is decided in parallel.
  always_comb begin
    int k;
    int s;
    int c;
    int d;
    sb_o = sb_i;
    db_o = db_i;
    gv_o = gv_i;
    gd_o = gd_i;
    s = 0;
    c = 0;
    d = 0;
    k = int'(cyc) * D + J;
    if (k < N) begin
      for (int p = 0; p < N; p++) begin
        s = wrap_add(p, int'(rs), N);
        c = wrap_add(p, k, N);
        d = wrap_add(c, int'(rd), N);
        if (req[s*N+d] && !sb_i[s] && !db_i[d] && !inh[d] && (fe[s] ^ pass_lc)) begin
          sb_o[s]           = 1'b1;
          db_o[d]           = 1'b1;
          gv_o[s]           = 1'b1;
          gd_o[s*IW +: IW]  = IW'(d);
        end
      end
    end
  end

endmodule

// File: rtl/xbar_wavefront.sv
module xbar_wavefront #(
  parameter int N  = 15,
  parameter int D  = 4,
  parameter int CW = 2,
  parameter int IW = 4
) (
  input  logic [CW-1:0]   cyc,
  input  logic            pass_lc,
  input  logic [N*N-1:0]  req,
  input  logic [N-1:0]    inh,
  input  logic [N-1:0]    fe,
  input  logic [IW-1:0]   rs,
  input  logic [IW-1:0]   rd,
  input  logic [N-1:0]    sb_i,
  input  logic [N-1:0]    db_i,
  input  logic [N-1:0]    gv_i,
  input  logic [N*IW-1:0] gd_i,
  output logic [N-1:0]    sb_o,
  output logic [N-1:0]    db_o,
  output logic [N-1:0]    gv_o,
  output logic [N*IW-1:0] gd_o
);

  logic [D:0][N-1:0]    sb;
  logic [D:0][N-1:0]    db;
  logic [D:0][N-1:0]    gv;
  logic [D:0][N*IW-1:0] gd;

  assign sb[0] = sb_i;
  assign db[0] = db_i;
  assign gv[0] = gv_i;
  assign gd[0] = gd_i;

  // D diagonals per cycle, each stage seeing the busy masks of the one before.
  for (genvar j = 0; j < D; j++) begin : g_stage
    xbar_diag_stage #(.N(N), .D(D), .J(j), .CW(CW), .IW(IW)) u_stage (
      .cyc    (cyc),
      .pass_lc(pass_lc),
      .req    (req),
      .inh    (inh),
      .fe     (fe),
      .rs     (rs),
      .rd     (rd),
      .sb_i   (sb[j]),
      .db_i   (db[j]),
      .gv_i   (gv[j]),
      .gd_i   (gd[j]),
      .sb_o   (sb[j+1]),
      .db_o   (db[j+1]),
      .gv_o   (gv[j+1]),
      .gd_o   (gd[j+1])
    );
  end

  assign sb_o = sb[D];
  assign db_o = db[D];
  assign gv_o = gv[D];
  assign gd_o = gd[D];

endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc
  import xbar_alloc_pkg::*;
#(
  parameter int           N    = 15,
  parameter int           D    = 4,
  parameter int           LW   = 16,
  parameter logic [LW-1:0] SEED = 16'hACE1,
  parameter logic [LW-1:0] TAPS = 16'hB400,
  localparam int          IW   = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [N*N-1:0]  req,
  input  logic [N-1:0]    inhibit,
  input  logic [N-1:0]    fe_card,
  output logic            done,
  output logic [N-1:0]    grant_vld,
  output logic [N*IW-1:0] grant_dst
);

  localparam int CPP  = (N + D - 1) / D;
  localparam int CW   = width_min1(CPP);
  localparam int HALF = LW / 2;

  logic            busy;
  logic            pass_lc;
  logic [CW-1:0]   cyc;
  logic [N*N-1:0]  req_q;
  logic [N-1:0]    inh_q;
  logic [N-1:0]    fe_q;
  logic [IW-1:0]   rs_q;
  logic [IW-1:0]   rd_q;
  logic [N-1:0]    sb_q;
  logic [N-1:0]    db_q;
  logic [N-1:0]    gv_q;
  logic [N*IW-1:0] gd_q;
  logic [N-1:0]    sb_n;
  logic [N-1:0]    db_n;
  logic [N-1:0]    gv_n;
  logic [N*IW-1:0] gd_n;
  logic [LW-1:0]   lfsr_st;
  logic            accept;

  assign accept = start && !busy;

  xbar_lfsr #(.W(LW), .SEED(SEED), .TAPS(TAPS)) u_lfsr (
    .clk  (clk),
    .rst  (rst),
    .adv  (accept),
    .state(lfsr_st)
  );

  xbar_wavefront #(.N(N), .D(D), .CW(CW), .IW(IW)) u_wave (
    .cyc    (cyc),
    .pass_lc(pass_lc),
    .req    (req_q),
    .inh    (inh_q),
    .fe     (fe_q),
    .rs     (rs_q),
    .rd     (rd_q),
    .sb_i   (sb_q),
    .db_i   (db_q),
    .gv_i   (gv_q),
    .gd_i   (gd_q),
    .sb_o   (sb_n),
    .db_o   (db_n),
    .gv_o   (gv_n),
    .gd_o   (gd_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      pass_lc   <= 1'b0;
      cyc       <= '0;
      req_q     <= '0;
      inh_q     <= '0;
      fe_q      <= '0;
      rs_q      <= '0;
      rd_q      <= '0;
      sb_q      <= '0;
      db_q      <= '0;
      gv_q      <= '0;
      gd_q      <= '0;
      done      <= 1'b0;
      grant_vld <= '0;
      grant_dst <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        pass_lc <= 1'b0;
        cyc     <= '0;
        req_q   <= req;
        inh_q   <= inhibit;
        fe_q    <= fe_card;
        rs_q    <= IW'(32'(lfsr_st[HALF-1:0]) % N);
        rd_q    <= IW'(32'(lfsr_st[LW-1:HALF]) % N);
        sb_q    <= '0;
        db_q    <= '0;
        gv_q    <= '0;
        gd_q    <= '0;
      end else if (busy) begin
        sb_q <= sb_n;
        db_q <= db_n;
        gv_q <= gv_n;
        gd_q <= gd_n;
        if (cyc == CW'(CPP - 1)) begin
          cyc <= '0;
          if (pass_lc) begin
            busy      <= 1'b0;
            pass_lc   <= 1'b0;
            done      <= 1'b1;
            grant_vld <= gv_n;
            grant_dst <= gd_n;
          end else begin
            pass_lc <= 1'b1;
          end
        end else begin
          cyc <= cyc + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/xbar_alloc_chk.sv
module xbar_alloc_chk #(
  parameter int N   = 15,
  parameter int IW  = 4,
  parameter int LAT = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [N-1:0]    grant_vld,
  input logic [N*IW-1:0] grant_dst,
  input logic [N*N-1:0]  req_q,
  input logic [N-1:0]    inh_q
);

  logic [15:0]  cnt;
  logic         dup_ok;
  logic         legal_ok;
  logic [N-1:0] used;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (start && !busy) cnt <= '0;
    else if (busy) cnt <= cnt + 16'd1;
  end

  always_comb begin
    int d;
    dup_ok   = 1'b1;
    legal_ok = 1'b1;
    used     = '0;
    d        = 0;
    for (int s = 0; s < N; s++) begin
      if (grant_vld[s]) begin
        d = int'(grant_dst[s*IW +: IW]);
        if (d >= N) begin
          legal_ok = 1'b0;
        end else begin
          if (used[d]) dup_ok = 1'b0;
          used[d] = 1'b1;
          if (!req_q[s*N+d] || inh_q[d]) legal_ok = 1'b0;
        end
      end
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R2
  done_latency_chk: assert property (@(posedge clk) disable iff (rst) done |-> (cnt == 16'(LAT)));

  // R3
  dest_unique_chk: assert property (@(posedge clk) disable iff (rst) done |-> dup_ok);

  // R4 R5
  grant_legal_chk: assert property (@(posedge clk) disable iff (rst) done |-> legal_ok);

  // R11
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(grant_vld) && $stable(grant_dst)));

endmodule

bind xbar_alloc xbar_alloc_chk #(.N(N), .IW(IW), .LAT(2*CPP)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .grant_vld(grant_vld),
  .grant_dst(grant_dst),
  .req_q    (req_q),
  .inh_q    (inh_q)
);

// File: tb/sim_xbar_alloc.sv
module sim_xbar_alloc;

  localparam int N   = 15;
  localparam int D   = 4;
  localparam int IW  = $clog2(N);
  localparam int NN  = N * N;
  localparam int LAT = 2 * ((N + D - 1) / D);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [NN-1:0]   req_i = '0;
  logic [N-1:0]    inh_i = '0;
  logic [N-1:0]    fe_i = '0;
  logic            done;
  logic [N-1:0]    gv;
  logic [N*IW-1:0] gd;

  always #4 clk = ~clk;

  xbar_alloc #(.N(N), .D(D)) u0 (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .req      (req_i),
    .inhibit  (inh_i),
    .fe_card  (fe_i),
    .done     (done),
    .grant_vld(gv),
    .grant_dst(gd)
  );

  int checks = 0;
  int errors = 0;
  int cyc_n  = 0;

  always @(posedge clk) cyc_n++;

  typedef struct {
    logic [NN-1:0] req;
    logic [N-1:0]  inh;
    logic [N-1:0]  fe;
    int            t0;
  } item_t;

  item_t exp_q[$];

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int gdst(input int s);
    return int'(gd[s*IW +: IW]);
  endfunction

  // Compare one result against the request set captured at its start.
  task automatic score(input item_t it);
    logic [N-1:0] used;
    logic [N-1:0] used_fe;
    int dup, badreq, badinh, unmaxed, fe_bad, d;
    used = '0; used_fe = '0;
    dup = 0; badreq = 0; badinh = 0; unmaxed = 0; fe_bad = 0;
    for (int s = 0; s < N; s++) begin
      if (gv[s]) begin
        d = gdst(s);
        if (d >= N) begin
          badreq++;
        end else begin
          if (used[d]) dup++;
          used[d] = 1'b1;
          if (it.fe[s]) used_fe[d] = 1'b1;
          if (!it.req[s*N+d]) badreq++;
          if (it.inh[d]) badinh++;
        end
      end
    end
    for (int s = 0; s < N; s++) begin
      if (!gv[s]) begin
        for (int dd = 0; dd < N; dd++) begin
          if (it.req[s*N+dd] && !it.inh[dd]) begin
            if (!used[dd]) unmaxed++;
            if (it.fe[s] && !used_fe[dd]) fe_bad++;
          end
        end
      end
    end
    chk(cyc_n - it.t0 == LAT, "R2", "done latency", cyc_n - it.t0, LAT);
    chk(dup == 0, "R3", "duplicate destinations", dup, 0);
    chk(badreq == 0, "R4", "grants without request", badreq, 0);
    chk(badinh == 0, "R5", "grants to inhibited", badinh, 0);
    chk(unmaxed == 0, "R6", "missed free pairs", unmaxed, 0);
    chk(fe_bad == 0, "R7", "forwarding source passed over", fe_bad, 0);
  endtask

  // Monitor: pop the oldest expected epoch on each done pulse.
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) chk(1'b0, "R9", "unexpected done", 1, 0);
      else score(exp_q.pop_front());
    end
  end

  // Driver: launch one epoch and optionally disturb inputs mid-run.
  task automatic epoch(input logic [NN-1:0] r, input logic [N-1:0] ih,
                       input logic [N-1:0] f, input bit disturb);
    item_t it;
    @(negedge clk);
    req_i = r; inh_i = ih; fe_i = f; start = 1'b1;
    @(posedge clk);
    #1;
    it.req = r; it.inh = ih; it.fe = f; it.t0 = cyc_n;
    exp_q.push_back(it);
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      req_i = '0; inh_i = '1; fe_i = ~f;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    if (disturb) repeat (12) @(negedge clk);
    #1;
  endtask

  function automatic logic [NN-1:0] rand_req(input int pct);
    logic [NN-1:0] r;
    for (int i = 0; i < NN; i++) r[i] = (($urandom % 100) < pct);
    return r;
  endfunction

  function automatic logic [N-1:0] rand_vec(input int pct);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (($urandom % 100) < pct);
    return v;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [NN-1:0]   r;
    logic [N-1:0]    ih;
    logic [N-1:0]    f;
    logic [N-1:0]    snap_v;
    logic [N*IW-1:0] snap_d;
    int w0, w5;

    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(gv == '0, "R1", "grant_vld after reset", int'(gv), 0);

    // R4 single request gets exactly that pair
    r = '0; r[2*N+9] = 1'b1;
    epoch(r, '0, '0, 1'b0);
    chk(gv[2] && gdst(2) == 9, "R4", "single pair dest", gdst(2), 9);
    chk($countones(gv) == 1, "R4", "single pair count", $countones(gv), 1);

    // R5 same request toward an inhibited destination
    ih = '0; ih[9] = 1'b1;
    epoch(r, ih, '0, 1'b0);
    chk(gv == '0, "R5", "inhibited dest granted", int'(gv), 0);

    // R7 forwarding card beats line card under every shuffle; R11 hold
    for (int e = 0; e < 6; e++) begin
      r = '0; r[1*N+4] = 1'b1; r[7*N+4] = 1'b1;
      f = '0; f[7] = 1'b1;
      epoch(r, '0, f, 1'b0);
      chk(gv[7] && gdst(7) == 4, "R7", "fe source wins", int'(gv[7]), 1);
      chk(!gv[1], "R7", "line card loses", int'(gv[1]), 0);
      snap_v = gv; snap_d = gd;
      repeat (3) @(negedge clk);
      chk(gv == snap_v && gd == snap_d, "R11", "grants held", int'(gv), int'(snap_v));
    end

    // R8 R9 inputs scrambled and start re-pulsed mid-run
    epoch('1, '0, 15'h0421, 1'b1);
    chk($countones(gv) == N, "R8", "full matrix grants", $countones(gv), N);

    // R3-R7 random matrices of varying density
    for (int e = 0; e < 40; e++) begin
      epoch(rand_req(3 + (e % 8) * 8), rand_vec(20), rand_vec(30), 1'b0);
    end

    // R10 two line cards contend for one destination
    w0 = 0; w5 = 0;
    for (int e = 0; e < 64; e++) begin
      r = '0; r[0*N+3] = 1'b1; r[5*N+3] = 1'b1;
      epoch(r, '0, '0, 1'b0);
      if (gv[0]) w0++;
      if (gv[5]) w5++;
      chk($countones(gv) == 1, "R10", "exactly one winner", $countones(gv), 1);
    end
    chk(w0 >= 8, "R10", "source 0 wins", w0, 8);
    chk(w5 >= 8, "R10", "source 5 wins", w5, 8);

    summary();
    $finish;
  end

endmodule